// File: doc/BRIEF.md
# Background Tile Pixel Shifter

This block turns fetched background tile data into a stream of 4-bit palette indices, one per pixel dot. A fetch sequencer outside the block places words on a shared 16-bit data bus and pulses one of three strobes. The first strobe captures the tile's name-table entry. The other two capture the two pattern words, which together hold four bitplane bytes. The horizontal-flip bit of the captured entry decides whether each byte is stored as it arrives or with its bit order reversed. No shifter ever has to run in reverse.

The pattern bytes go into a holding stage first. On the last dot of the tile now on screen, the holding stage moves into four plane shift registers. The sequencer can therefore fetch the next tile while the current one is still being displayed, and there is no gap between tiles. Each dot-enable pulse shifts every plane one place toward its MSB and registers one pixel. The entry's palette-select and priority bits travel with their tile and appear beside the pixel index. The pixel stream cannot stall, so it has a valid flag and no ready: whoever consumes it must accept a pixel on every cycle that the flag is high.

Top module: `bg_tile_shifter`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, pix_valid, pix_index, pix_pal and pix_pri are all 0.
- R2: A pulse on ent_ld captures bus_data bit 9 as the flip flag, bit 11 as palette select and bit 12 as priority. These values are used by every later pattern load until the next ent_ld.
- R3: A pulse on pat_lo_ld stores the low byte of bus_data as plane 0 and the high byte as plane 1. A pulse on pat_hi_ld stores the low byte as plane 2 and the high byte as plane 3. Both go into the holding stage.
- R4: If the captured flip flag is set when a pattern word loads, each byte is stored bit-reversed (bit 0 becomes bit 7, and so on). If the flag is clear, the byte is stored unchanged.
- R5: The pixel at tile column k (k = 0 is the leftmost) is {plane3[7-k], plane2[7-k], plane1[7-k], plane0[7-k]} of the stored bytes, so plane 0 gives the least significant bit.
- R6: The holding stage moves into the shifters on the first dot_en after reset and then on every 8th dot_en after that. Tiles follow one another with no gap.
- R7: The cycle after a dot_en, pix_valid is 1 and the outputs show one pixel. The n-th dot (counting from 0) shows pixel n-1 of the tile stream, and dot 0 shows index 0.
- R8: On a cycle without dot_en, pix_valid goes low and the pixel, palette and priority outputs and the shifter state all hold. Strobes that arrive on such cycles change none of these outputs.
- R9: pat_hi_ld copies the captured palette and priority bits into the holding stage. They reach pix_pal and pix_pri on the same dots as that tile's pixels.
- R10: Loads into the holding stage while a tile is being shifted out do not change any of that tile's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | 16 | Shared fetch data bus |
| ent_ld | input | 1 | Capture the name-table entry from bus_data |
| pat_lo_ld | input | 1 | Capture pattern word for planes 0 and 1 |
| pat_hi_ld | input | 1 | Capture pattern word for planes 2 and 3 and the tile attributes |
| dot_en | input | 1 | Advance one pixel dot |
| pix_valid | output | 1 | Output pixel updated on the previous cycle |
| pix_index | output | 4 | Palette index of the pixel |
| pix_pal | output | 1 | Palette select of the pixel's tile |
| pix_pri | output | 1 | Priority of the pixel's tile |

## Verification
The properties assume that only one strobe pulses in a cycle. They also assume the fetch sequencer fills the holding stage once per tile, between two transfer dots, and never on the dot that performs a transfer. The stimulus keeps to this. Each tile's entry and pattern words are loaded on the third, fourth and fifth dots of the tile before it. Idle cycles with dot_en low are inserted at random and never carry a strobe. The only exception is the first tile, which is loaded with dot_en low before any dot. Entry words and pattern words are random, including the flip bit. A few directed tiles pin down bit reversal, the plane order and the attribute bits.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  localparam int ENTRY_FLIP_BIT = 9;
  localparam int ENTRY_PAL_BIT  = 11;
  localparam int ENTRY_PRI_BIT  = 12;

  typedef struct packed {
    logic pal;
    logic pri;
  } tile_attr_t;
endpackage

// File: rtl/bgs_entry_reg.sv
module bgs_entry_reg
  import bgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic       flip_in,
  input  logic       pal_in,
  input  logic       pri_in,
  output logic       flip,
  output tile_attr_t attr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flip <= 1'b0;
      attr <= '0;
    end else if (ld) begin
      flip     <= flip_in;
      attr.pal <= pal_in;
      attr.pri <= pri_in;
    end
  end
endmodule

// File: rtl/bgs_pattern_hold.sv
module bgs_pattern_hold
  import bgs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PLANE_W   = 8,
  parameter int PLANES    = 4,
  parameter int NUM_WORDS = PLANES * PLANE_W / DATA_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WORDS-1:0]        ld,
  input  logic [DATA_W-1:0]           data,
  input  logic                        flip,
  input  tile_attr_t                  attr_in,
  output logic [PLANES*PLANE_W-1:0]   hold_flat,
  output tile_attr_t                  hold_attr
);
  localparam int LANES = DATA_W / PLANE_W;

  function automatic logic [PLANE_W-1:0] mirror(input logic [PLANE_W-1:0] b);
    logic [PLANE_W-1:0] r;
    for (int i = 0; i < PLANE_W; i++) r[i] = b[PLANE_W-1-i];
    return r;
  endfunction

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    localparam int WORD = p / LANES;
    localparam int LANE = p % LANES;
    logic [PLANE_W-1:0] lane_byte;
    assign lane_byte = data[LANE*PLANE_W +: PLANE_W];

    always_ff @(posedge clk) begin
      if (!rst_n)
        hold_flat[p*PLANE_W +: PLANE_W] <= '0;
      else if (ld[WORD])
        hold_flat[p*PLANE_W +: PLANE_W] <= flip ? mirror(lane_byte) : lane_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      hold_attr <= '0;
    else if (ld[NUM_WORDS-1])
      hold_attr <= attr_in;
  end
endmodule

// File: rtl/bgs_plane_shifter.sv
module bgs_plane_shifter
  import bgs_pkg::*;
#(
  parameter int PLANE_W = 8,
  parameter int PLANES  = 4,
  parameter int CNT_W   = $clog2(PLANE_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dot_en,
  input  logic [PLANES*PLANE_W-1:0] hold_flat,
  input  tile_attr_t                hold_attr,
  output logic [PLANES*PLANE_W-1:0] shift_flat,
  output tile_attr_t                sh_attr,
  output logic [CNT_W-1:0]          phase,
  output logic [PLANES-1:0]         msb
);
  localparam logic [CNT_W-1:0] PHASE_LAST = CNT_W'(PLANE_W - 1);

  logic reload;
  assign reload = (phase == PHASE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)
      phase <= PHASE_LAST;
    else if (dot_en)
      phase <= reload ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sh_attr <= '0;
    else if (dot_en && reload)
      sh_attr <= hold_attr;
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_shift
    always_ff @(posedge clk) begin
      if (!rst_n)
        shift_flat[p*PLANE_W +: PLANE_W] <= '0;
      else if (dot_en) begin
        if (reload)
          shift_flat[p*PLANE_W +: PLANE_W] <= hold_flat[p*PLANE_W +: PLANE_W];
        else
          shift_flat[p*PLANE_W +: PLANE_W] <= {shift_flat[p*PLANE_W +: PLANE_W-1], 1'b0};
      end
    end
    assign msb[p] = shift_flat[p*PLANE_W + PLANE_W - 1];
  end
endmodule

// File: rtl/bg_tile_shifter.sv
module bg_tile_shifter
  import bgs_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PLANE_W = 8,
  parameter int PLANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              ent_ld,
  input  logic              pat_lo_ld,
  input  logic              pat_hi_ld,
  input  logic              dot_en,
  output logic              pix_valid,
  output logic [PLANES-1:0] pix_index,
  output logic              pix_pal,
  output logic              pix_pri
);
  localparam int CNT_W     = $clog2(PLANE_W);
  localparam int NUM_WORDS = PLANES * PLANE_W / DATA_W;

  logic                      ent_flip;
  tile_attr_t                ent_attr;
  tile_attr_t                hold_attr;
  tile_attr_t                sh_attr;
  logic [PLANES*PLANE_W-1:0] hold_flat;
  logic [PLANES*PLANE_W-1:0] shift_flat;
  logic [CNT_W-1:0]          phase;
  logic [PLANES-1:0]         msb;
  logic [NUM_WORDS-1:0]      pat_ld;

  assign pat_ld = {pat_hi_ld, pat_lo_ld};

  bgs_entry_reg u_entry (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ent_ld),
    .flip_in (bus_data[ENTRY_FLIP_BIT]),
    .pal_in  (bus_data[ENTRY_PAL_BIT]),
    .pri_in  (bus_data[ENTRY_PRI_BIT]),
    .flip    (ent_flip),
    .attr    (ent_attr)
  );

  bgs_pattern_hold #(
    .DATA_W  (DATA_W),
    .PLANE_W (PLANE_W),
    .PLANES  (PLANES)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (pat_ld),
    .data      (bus_data),
    .flip      (ent_flip),
    .attr_in   (ent_attr),
    .hold_flat (hold_flat),
    .hold_attr (hold_attr)
  );

  bgs_plane_shifter #(
    .PLANE_W (PLANE_W),
    .PLANES  (PLANES),
    .CNT_W   (CNT_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .dot_en     (dot_en),
    .hold_flat  (hold_flat),
    .hold_attr  (hold_attr),
    .shift_flat (shift_flat),
    .sh_attr    (sh_attr),
    .phase      (phase),
    .msb        (msb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_index <= '0;
      pix_pal   <= 1'b0;
      pix_pri   <= 1'b0;
    end else begin
      pix_valid <= dot_en;
      if (dot_en) begin
        pix_index <= msb;
        pix_pal   <= sh_attr.pal;
        pix_pri   <= sh_attr.pri;
      end
    end
  end
endmodule

// File: rtl/bg_tile_shifter_chk.sv
module bg_tile_shifter_chk #(
  parameter int PLANE_W = 8,
  parameter int PLANES  = 4,
  parameter int CNT_W   = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      dot_en,
  input logic                      pix_valid,
  input logic [PLANES-1:0]         pix_index,
  input logic                      pix_pal,
  input logic                      pix_pri,
  input logic [PLANES*PLANE_W-1:0] hold_flat,
  input logic [PLANES*PLANE_W-1:0] shift_flat,
  input logic                      sh_pal,
  input logic                      sh_pri,
  input logic [CNT_W-1:0]          phase
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PLANE_W - 1);

  logic [PLANES-1:0] top_bits;
  for (genvar p = 0; p < PLANES; p++) begin : g_top
    assign top_bits[p] = shift_flat[p*PLANE_W + PLANE_W - 1];

    // R5: planes move one place toward the MSB on a dot that does not transfer
    p_plane_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dot_en && phase != LAST) |=>
        shift_flat[p*PLANE_W +: PLANE_W] == {$past(shift_flat[p*PLANE_W +: PLANE_W-1]), 1'b0});
  end

  // R6: the transfer dot copies the holding stage into the shifters
  p_transfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_en && phase == LAST) |=> shift_flat == $past(hold_flat));

  // R6: the phase returns to zero after a transfer dot
  p_phase_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_en && phase == LAST) |=> phase == '0);

  // R7: a dot yields a valid pixel taken from the plane MSBs
  p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dot_en |=> pix_valid && pix_index == $past(top_bits));

  // R9: the attributes follow the tile in the shifters
  p_attr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dot_en |=> pix_pal == $past(sh_pal) && pix_pri == $past(sh_pri));

  // R8: nothing advances without a dot
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> !pix_valid && $stable(pix_index) && $stable(pix_pal) && $stable(pix_pri)
                && $stable(shift_flat) && $stable(phase));
endmodule

bind bg_tile_shifter bg_tile_shifter_chk #(
  .PLANE_W (PLANE_W),
  .PLANES  (PLANES),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dot_en     (dot_en),
  .pix_valid  (pix_valid),
  .pix_index  (pix_index),
  .pix_pal    (pix_pal),
  .pix_pri    (pix_pri),
  .hold_flat  (hold_flat),
  .shift_flat (shift_flat),
  .sh_pal     (sh_attr.pal),
  .sh_pri     (sh_attr.pri),
  .phase      (phase)
);

// File: tb/bg_tile_shifter_test.sv
module bg_tile_shifter_test;
  localparam int NT = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_data;
  logic        ent_ld, pat_lo_ld, pat_hi_ld, dot_en;
  logic        pix_valid, pix_pal, pix_pri;
  logic [3:0]  pix_index;

  always #10 clk = ~clk;

  bg_tile_shifter uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_data  (bus_data),
    .ent_ld    (ent_ld),
    .pat_lo_ld (pat_lo_ld),
    .pat_hi_ld (pat_hi_ld),
    .dot_en    (dot_en),
    .pix_valid (pix_valid),
    .pix_index (pix_index),
    .pix_pal   (pix_pal),
    .pix_pri   (pix_pri)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int m      = 0;
  logic [15:0] t_ent [NT+1];
  logic [15:0] t_w0  [NT+1];
  logic [15:0] t_w1  [NT+1];
  logic [3:0]  e_pix = '0;
  logic        e_pal = 1'b0;
  logic        e_pri = 1'b0;

  // R4 R5: pixel k of a tile computed from the raw words
  function automatic logic [3:0] exp_pix(logic [15:0] e, logic [15:0] w0, logic [15:0] w1, int k);
    logic [7:0] b [4];
    logic [3:0] r;
    int idx;
    b[0] = w0[7:0]; b[1] = w0[15:8]; b[2] = w1[7:0]; b[3] = w1[15:8];
    idx = e[9] ? k : 7 - k;
    for (int p = 0; p < 4; p++) r[p] = b[p][idx];
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at time %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit de, bit le, bit l0, bit l1, logic [15:0] d);
    int t, k;
    @(negedge clk);
    dot_en = de; ent_ld = le; pat_lo_ld = l0; pat_hi_ld = l1; bus_data = d;
    @(posedge clk);
    #1;
    if (de) begin
      if (m > 0) begin
        t = (m - 1) / 8;
        k = (m - 1) % 8;
        e_pix = exp_pix(t_ent[t], t_w0[t], t_w1[t], k);
        e_pal = t_ent[t][11];
        e_pri = t_ent[t][12];
      end
      m++;
    end
    check(de ? "R7 valid after dot" : "R8 valid low without dot", int'(pix_valid), int'(de));
    check("R5 R4 R3 R6 R10 pixel index", int'(pix_index), int'(e_pix));
    check("R9 R2 palette select", int'(pix_pal), int'(e_pal));
    check("R9 R2 priority", int'(pix_pri), int'(e_pri));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired, dots=%0d", m);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    // directed tiles: flip with asymmetric bytes, same without flip, all ones, plane markers
    t_ent[0] = 16'h0A00; t_w0[0] = 16'h8001; t_w1[0] = 16'hC003;
    t_ent[1] = 16'h1000; t_w0[1] = 16'h8001; t_w1[1] = 16'hC003;
    t_ent[2] = 16'h1A00; t_w0[2] = 16'hFFFF; t_w1[2] = 16'hFFFF;
    t_ent[3] = 16'h0000; t_w0[3] = 16'h4080; t_w1[3] = 16'h1020;
    for (int i = 4; i <= NT; i++) begin
      t_ent[i] = 16'($urandom);
      t_w0[i]  = 16'($urandom);
      t_w1[i]  = 16'($urandom);
    end

    rst_n = 1'b0; dot_en = 0; ent_ld = 0; pat_lo_ld = 0; pat_hi_ld = 0; bus_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", int'(pix_valid), 0);
    check("R1 reset index", int'(pix_index), 0);
    check("R1 reset palette", int'(pix_pal), 0);
    check("R1 reset priority", int'(pix_pri), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: first tile loaded with no dots, outputs stay at reset values
    step(0, 1, 0, 0, t_ent[0]);
    step(0, 0, 1, 0, t_w0[0]);
    step(0, 0, 0, 1, t_w1[0]);

    // R6 R10: gapless stream, next tile fetched during dots 2..4
    for (int g = 0; g <= NT; g++) begin
      for (int d = 0; d < 8; d++) begin
        while (g > 3 && ($urandom % 4) == 0) step(0, 0, 0, 0, 16'($urandom));
        if (g < NT && d == 2)      step(1, 1, 0, 0, t_ent[g+1]);
        else if (g < NT && d == 3) step(1, 0, 1, 0, t_w0[g+1]);
        else if (g < NT && d == 4) step(1, 0, 0, 1, t_w1[g+1]);
        else                       step(1, 0, 0, 0, 16'($urandom));
      end
    end
    step(0, 0, 0, 0, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule